// File: doc/BRIEF.md
# DDR Burst Column Address Generator

This block produces the column address of every data element in one memory burst. A controller pulses a start strobe together with the first column, a 3-bit burst-length code and an ordering bit; from the next cycle the block presents one column address per clock, with a valid flag, until the burst is complete. The final beat is marked with a last flag.

Addresses never leave the aligned block whose size is the burst length. The column bits above that block are taken from the starting column and stay fixed. Only the low bits inside the block move, either in sequential (modulo) order or in interleaved (XOR) order.

A terminate strobe cuts the running burst short. A fresh start strobe on any cycle replaces the running burst. A burst-length code outside the supported set is run as a two-beat burst and raises a sticky error flag.

Top module: `ddr_colgen`

## Requirements
- R1: After reset, `valid_o`, `last_o` and `bl_err_o` are all low.
- R2: When `start_i` is high at a clock edge, `valid_o` is high from that edge on, and `col_o` equals `start_col_i`. One further address is presented on each later clock.
- R3: With `order_i` = 0 (sequential), beat i has low bits equal to (s + i) mod L. Here s is the starting column's low bits and L is the burst length.
- R4: With `order_i` = 1 (interleaved), beat i has low bits equal to s XOR i.
- R5: The burst-length code selects the burst length: code 3'b001 gives 2 beats, 3'b010 gives 4 beats and 3'b011 gives 8 beats.
- R6: The column bits at and above log2(L) keep the starting column's value for the whole burst. Wrapping at the block edge never carries into them.
- R7: `last_o` is high exactly on the final beat. On the next cycle `valid_o` is low unless `start_i` was high on that edge.
- R8: When `term_i` is high at an edge and `start_i` is low, `valid_o` is low after that edge. If both are high, the start wins.
- R9: A start during a running burst discards it. The new burst's beat 0 appears on the next cycle.
- R10: Length code and ordering bit are sampled only with `start_i`. Changing them during a burst has no effect on its addresses or length.
- R11: Codes other than 3'b001, 3'b010 and 3'b011 run as a 2-beat burst. They also set `bl_err_o`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a burst at `start_col_i` |
| start_col_i | input | COL_W | Starting column address |
| bl_code_i | input | 3 | Burst-length code |
| order_i | input | 1 | 0 = sequential, 1 = interleaved |
| term_i | input | 1 | Truncate the running burst |
| col_o | output | COL_W | Current column address |
| valid_o | output | 1 | `col_o` holds a burst beat |
| last_o | output | 1 | Current beat is the final one |
| bl_err_o | output | 1 | Sticky flag: a reserved length code was started |

## Verification
The properties assume that the reset is held for at least one edge before any strobe matters. They also assume that `start_i` and `term_i` are single-cycle qualifiers sampled only at rising edges. The block-stability property further assumes that a burst is not restarted on the cycle being compared. The stimulus changes inputs only on falling edges. Between bursts it returns both strobes to low, apart from the deliberate overlap cases: a start together with a terminate, a start on the last beat, and a start in mid-burst. These cases are placed so that every property still sees a well-defined previous cycle.

// File: rtl/ddr_colgen_pkg.sv
package ddr_colgen_pkg;

    localparam int OFS_W = 3;

    localparam logic [2:0] CODE_BL2 = 3'b001;
    localparam logic [2:0] CODE_BL4 = 3'b010;
    localparam logic [2:0] CODE_BL8 = 3'b011;

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_XOR = 1'b1
    } order_e;

    typedef struct packed {
        logic [1:0] len_log2;
        order_e     order;
    } burst_cfg_t;

    function automatic logic code_is_reserved(input logic [2:0] code);
        return !(code == CODE_BL2 || code == CODE_BL4 || code == CODE_BL8);
    endfunction

    function automatic logic [1:0] code_to_log2(input logic [2:0] code);
        logic [1:0] l;
        case (code)
            CODE_BL4: l = 2'd2;
            CODE_BL8: l = 2'd3;
            default:  l = 2'd1;
        endcase
        return l;
    endfunction

    function automatic logic [OFS_W-1:0] len_mask(input logic [1:0] len_log2);
        logic [OFS_W-1:0] m;
        case (len_log2)
            2'd2:    m = 3'b011;
            2'd3:    m = 3'b111;
            default: m = 3'b001;
        endcase
        return m;
    endfunction

    function automatic logic [OFS_W-1:0] beat_offset(
        input order_e           order,
        input logic [OFS_W-1:0] start_low,
        input logic [OFS_W-1:0] beat,
        input logic [OFS_W-1:0] mask
    );
        logic [OFS_W-1:0] o;
        if (order == ORD_XOR) o = start_low ^ beat;
        else                  o = start_low + beat;
        return o & mask;
    endfunction

endpackage

// File: rtl/ddr_colgen_decode.sv
module ddr_colgen_decode
    import ddr_colgen_pkg::*;
(
    input  logic [2:0]  code_i,
    input  logic        order_i,
    output burst_cfg_t  cfg_o,
    output logic        reserved_o
);

    always_comb begin
        cfg_o.len_log2 = code_to_log2(code_i);
        cfg_o.order    = order_e'(order_i);
        reserved_o     = code_is_reserved(code_i);
    end

endmodule

// File: rtl/ddr_colgen_seq.sv
module ddr_colgen_seq
    import ddr_colgen_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             term_i,
    input  burst_cfg_t       cfg_i,
    output burst_cfg_t       cfg_q_o,
    output logic [OFS_W-1:0] beat_o,
    output logic [OFS_W-1:0] mask_o,
    output logic             active_o,
    output logic             last_o
);

    burst_cfg_t       cfg_q;
    logic [OFS_W-1:0] beat_q;
    logic             active_q;
    logic [OFS_W-1:0] mask;
    logic             at_end;

    assign mask   = len_mask(cfg_q.len_log2);
    assign at_end = active_q && (beat_q == mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q       <= 1'b0;
            beat_q         <= '0;
            cfg_q.len_log2 <= 2'd1;
            cfg_q.order    <= ORD_SEQ;
        end else if (start_i) begin
            active_q <= 1'b1;
            beat_q   <= '0;
            cfg_q    <= cfg_i;
        end else if (term_i) begin
            active_q <= 1'b0;
        end else if (active_q) begin
            if (at_end) active_q <= 1'b0;
            else        beat_q   <= beat_q + 1'b1;
        end
    end

    assign cfg_q_o  = cfg_q;
    assign beat_o   = beat_q;
    assign mask_o   = mask;
    assign active_o = active_q;
    assign last_o   = at_end;

endmodule

// File: rtl/ddr_colgen_addr.sv
module ddr_colgen_addr
    import ddr_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  order_e           order_i,
    input  logic [OFS_W-1:0] beat_i,
    input  logic [OFS_W-1:0] mask_i,
    output logic [COL_W-1:0] col_o
);

    localparam int UP_W = COL_W - OFS_W;

    logic [COL_W-1:0] base_q;
    logic [OFS_W-1:0] low_start;
    logic [OFS_W-1:0] low_beat;

    always_ff @(posedge clk) begin
        if (rst)          base_q <= '0;
        else if (start_i) base_q <= start_col_i;
    end

    assign low_start = base_q[OFS_W-1:0];
    assign low_beat  = beat_offset(order_i, low_start, beat_i, mask_i);

    assign col_o = {base_q[COL_W-1 -: UP_W], (low_start & ~mask_i) | low_beat};

endmodule

// File: rtl/ddr_colgen.sv
module ddr_colgen
    import ddr_colgen_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [2:0]       bl_code_i,
    input  logic             order_i,
    input  logic             term_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o,
    output logic             bl_err_o
);

    burst_cfg_t       cfg_new;
    burst_cfg_t       cfg_run;
    logic             reserved;
    logic [OFS_W-1:0] beat;
    logic [OFS_W-1:0] mask;
    logic             err_q;

    ddr_colgen_decode u_decode (
        .code_i     (bl_code_i),
        .order_i    (order_i),
        .cfg_o      (cfg_new),
        .reserved_o (reserved)
    );

    ddr_colgen_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .term_i   (term_i),
        .cfg_i    (cfg_new),
        .cfg_q_o  (cfg_run),
        .beat_o   (beat),
        .mask_o   (mask),
        .active_o (valid_o),
        .last_o   (last_o)
    );

    ddr_colgen_addr #(.COL_W(COL_W)) u_addr (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .start_col_i (start_col_i),
        .order_i     (cfg_run.order),
        .beat_i      (beat),
        .mask_i      (mask),
        .col_o       (col_o)
    );

    always_ff @(posedge clk) begin
        if (rst)                      err_q <= 1'b0;
        else if (start_i && reserved) err_q <= 1'b1;
    end

    assign bl_err_o = err_q;

endmodule

// File: rtl/ddr_colgen_chk.sv
module ddr_colgen_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic [2:0]       bl_code_i,
    input logic             term_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o,
    input logic             bl_err_o
);

    logic code_bad;
    assign code_bad = !(bl_code_i == 3'b001 || bl_code_i == 3'b010 || bl_code_i == 3'b011);

    p_start_valid_r2: assert property (@(posedge clk) disable iff (rst)
        start_i |=> valid_o);

    p_last_in_burst_r7: assert property (@(posedge clk) disable iff (rst)
        last_o |-> valid_o);

    p_last_ends_r7: assert property (@(posedge clk) disable iff (rst)
        (last_o && !start_i) |=> !valid_o);

    p_term_drops_r8: assert property (@(posedge clk) disable iff (rst)
        (term_i && !start_i) |=> !valid_o);

    p_block_fixed_r6: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !last_o && !start_i && !term_i) |=> $stable(col_o[COL_W-1:3]));

    p_err_set_r11: assert property (@(posedge clk) disable iff (rst)
        (start_i && code_bad) |=> bl_err_o);

    p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        bl_err_o |=> bl_err_o);

endmodule

bind ddr_colgen ddr_colgen_chk #(.COL_W(COL_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .bl_code_i (bl_code_i),
    .term_i    (term_i),
    .col_o     (col_o),
    .valid_o   (valid_o),
    .last_o    (last_o),
    .bl_err_o  (bl_err_o)
);

// File: tb/ddr_colgen_bench.sv
module ddr_colgen_bench;

    localparam int COL_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       bl_code_i = 3'b001;
    logic             order_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;
    logic             bl_err_o;

    int    total = 0;
    int    bad = 0;
    bit    finished = 0;
    string cur_req = "R1";

    int unsigned exp_q[$];
    bit          exp_err = 0;

    always #10 clk = ~clk;

    ddr_colgen #(.COL_W(COL_W)) u_ddr_colgen (
        .clk(clk), .rst(rst), .start_i(start_i), .start_col_i(start_col_i),
        .bl_code_i(bl_code_i), .order_i(order_i), .term_i(term_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o), .bl_err_o(bl_err_o)
    );

    function automatic int beats_of(input int code);
        if (code == 2) return 4;
        if (code == 3) return 8;
        return 2;
    endfunction

    task automatic model_edge();
        if (start_i) begin
            int len = beats_of(bl_code_i);
            int s   = int'(start_col_i);
            int blk = (s / len) * len;
            int ofs = s % len;
            exp_q.delete();
            for (int i = 0; i < len; i++) begin
                if (order_i) exp_q.push_back(blk + (ofs ^ i));
                else         exp_q.push_back(blk + ((ofs + i) % len));
            end
            if (bl_code_i == 0 || bl_code_i > 3) exp_err = 1;
        end else if (term_i) begin
            exp_q.delete();
        end else if (exp_q.size() > 0) begin
            void'(exp_q.pop_front());
        end
    endtask

    task automatic compare();
        bit ev = exp_q.size() > 0;
        total++;
        if (valid_o !== ev) begin
            bad++;
            $display("FAIL %s valid: got %0b exp %0b", cur_req, valid_o, ev);
        end
        total++;
        if (bl_err_o !== exp_err) begin
            bad++;
            $display("FAIL %s err: got %0b exp %0b", cur_req, bl_err_o, exp_err);
        end
        if (ev) begin
            total++;
            if (col_o !== exp_q[0][COL_W-1:0]) begin
                bad++;
                $display("FAIL %s col: got %h exp %h", cur_req, col_o, exp_q[0][COL_W-1:0]);
            end
        end
        total++;
        if (last_o !== (exp_q.size() == 1)) begin
            bad++;
            $display("FAIL %s last: got %0b exp %0b", cur_req, last_o, exp_q.size() == 1);
        end
    endtask

    task automatic step(input bit st, input int col, input int code, input bit ord, input bit tm);
        @(negedge clk);
        compare();
        start_i     = st;
        start_col_i = COL_W'(col);
        bl_code_i   = 3'(code);
        order_i     = ord;
        term_i      = tm;
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 1, 0, 0);
    endtask

    task automatic burst(input int col, input int code, input bit ord, input int gap);
        step(1, col, code, ord, 0);
        idle(gap);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        cur_req = "R1";  idle(2);
        cur_req = "R2";  burst('h0A6, 2, 0, 5);
        cur_req = "R3";  burst('h2A5, 3, 0, 9);
        cur_req = "R4";  burst('h135, 3, 1, 9);
        cur_req = "R4";  burst('h0C3, 2, 1, 5);
        cur_req = "R5";  burst('h011, 1, 0, 3);
        cur_req = "R5";  burst('h011, 1, 1, 3);
        cur_req = "R6";  burst('h3FF, 3, 0, 9);
        cur_req = "R6";  burst('h1FE, 2, 1, 5);
        cur_req = "R7";  step(1, 'h040, 2, 0, 0); idle(3);
        step(1, 'h085, 1, 1, 0); idle(3);
        cur_req = "R8";  step(1, 'h200, 3, 0, 0); idle(2);
        step(0, 0, 1, 0, 1); idle(2);
        step(1, 'h120, 3, 0, 0); idle(1);
        step(1, 'h077, 2, 1, 1); idle(5);
        cur_req = "R9";  step(1, 'h300, 3, 1, 0); idle(2);
        step(1, 'h0F2, 2, 0, 0); idle(5);
        cur_req = "R10"; step(1, 'h16C, 2, 0, 0);
        step(0, 'h3FF, 3, 1, 0); step(0, 'h000, 0, 1, 0); idle(4);
        cur_req = "R11"; idle(1);
        burst('h0B7, 0, 0, 3);
        burst('h0B6, 5, 1, 3);
        burst('h2B3, 7, 0, 3);
        burst('h051, 2, 0, 5);
        cur_req = "R3";
        for (int k = 0; k < 60; k++) begin
            int c = 1 + int'($urandom % 3);
            step(1, int'($urandom % 1024), c, 1'($urandom % 2), 0);
            idle(int'($urandom % 9));
        end
        @(negedge clk);
        compare();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule